// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a down-counting interval timer with a register port. Software sets a 32-bit period through two 16-bit halves, chooses one-shot or continuous operation, and starts the counter. The counter runs at the system clock, one count per cycle. When it passes zero it sets a sticky timeout flag and reloads itself from the period. In continuous mode it keeps going without help from software. In one-shot mode it clears its running flag and halts. A level interrupt is driven while the timeout flag is set and interrupts are enabled.

The register port is a plain single-cycle bus and has no back-pressure. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of `bus_addr` and the current register state. There is no valid/ready pair because every access completes in the cycle it is presented.

Top module: `pit_top`

## Requirements
- R1: After reset, the status register (address 0) and the control register (address 1) read 0. Both period halves (address 2 low, address 3 high) read 0xFFFF, so the period is 0xFFFFFFFF. The irq output is low.
- R2: The period is {high half, low half}. Writing either half stores the new half and reads it back. The write also clears the running flag and loads the counter with the new period.
- R3: Once started with period P, the timeout flag (status bit 0) first reads 1 exactly P+1 clock edges after the edge that wrote the start strobe.
- R4: In one-shot mode (control bit 1 = 0), expiry clears the running flag (status bit 1) and the counter halts. The counter is reloaded with the period, so a later start again takes P+1 edges.
- R5: In continuous mode (control bit 1 = 1), expiry reloads the counter from the period and the running flag stays 1. Later expiries follow every P+1 edges.
- R6: The timeout flag is sticky. Any write to address 0 clears it. If that write falls on an edge where an expiry happens, the flag stays set.
- R7: irq is high exactly while the timeout flag and the interrupt-enable bit (control bit 0) are both 1.
- R8: In the control register, bit 2 is a start strobe and bit 3 is a stop strobe. Both read as 0, and only bits 1:0 are stored. Stop wins when both strobes are written together. A stopped counter holds its value, and the next start resumes from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 status, 1 control, 2 period low, 3 period high |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
The bench measures expiry distance at the cycle level, including period zero. Period zero expires on every edge, so an off-by-one in the reload or in the zero test shows up as a wrong delay there. It writes the status register on an edge where the timer is also expiring; a design that lets the clear win would drop a timeout. It stops the counter partway through a run and then restarts it. A design that reloads on stop or start, instead of holding the count, would report a full period rather than the remainder. It also writes both strobes together, where a design giving start priority would be left running.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ADR_STATUS = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_PER_LO = 2'd2,
    ADR_PER_HI = 2'd3
  } pit_addr_e;

  localparam int CTL_IE    = 0;
  localparam int CTL_CONT  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_STOP  = 3;
  localparam int STS_TO    = 0;
  localparam int STS_RUN   = 1;
endpackage

// File: rtl/pit_count.sv
module pit_count #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  input  logic [PER_W-1:0] period,
  output logic             expire
);
  logic [PER_W-1:0] count;

  assign expire = run && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '1;
    else if (load)    count <= load_val;
    else if (expire)  count <= period;
    else if (run)     count <= count - 1'b1;
  end

  // R4 R5: expiry reloads the counter from the period
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> (count == $past(period)));

  // R8: a halted counter holds its value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int PER_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [HALF_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [HALF_W-1:0] bus_rdata,
  output logic [PER_W-1:0]  period,
  output logic              load,
  output logic [PER_W-1:0]  load_val,
  output logic              run,
  output logic              irq
);
  logic [HALF_W-1:0] per_lo, per_hi;
  logic ie, cont, tmo;
  logic wr_sts, wr_ctl, wr_lo, wr_hi, start_s, stop_s;

  assign wr_sts  = bus_we && (bus_addr == ADR_STATUS);
  assign wr_ctl  = bus_we && (bus_addr == ADR_CTRL);
  assign wr_lo   = bus_we && (bus_addr == ADR_PER_LO);
  assign wr_hi   = bus_we && (bus_addr == ADR_PER_HI);
  assign start_s = wr_ctl && bus_wdata[CTL_START];
  assign stop_s  = wr_ctl && bus_wdata[CTL_STOP];

  assign period   = {per_hi, per_lo};
  assign load     = wr_lo || wr_hi;
  assign load_val = wr_lo ? {per_hi, bus_wdata} : {bus_wdata, per_lo};
  assign irq      = tmo && ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_lo <= '1;
      per_hi <= '1;
      ie     <= 1'b0;
      cont   <= 1'b0;
      tmo    <= 1'b0;
      run    <= 1'b0;
    end else begin
      if (wr_lo) per_lo <= bus_wdata;
      if (wr_hi) per_hi <= bus_wdata;
      if (wr_ctl) begin
        ie   <= bus_wdata[CTL_IE];
        cont <= bus_wdata[CTL_CONT];
      end
      if (expire)      tmo <= 1'b1;
      else if (wr_sts) tmo <= 1'b0;
      if (stop_s || load)        run <= 1'b0;
      else if (start_s)          run <= 1'b1;
      else if (expire && !cont)  run <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_STATUS: begin
        bus_rdata[STS_TO]  = tmo;
        bus_rdata[STS_RUN] = run;
      end
      ADR_CTRL: begin
        bus_rdata[CTL_IE]   = ie;
        bus_rdata[CTL_CONT] = cont;
      end
      ADR_PER_LO: bus_rdata = per_lo;
      default:    bus_rdata = per_hi;
    endcase
  end

  // R3: expiry sets the timeout flag
  p_expire_sets_to_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo);
  // R4: one-shot expiry halts the timer
  p_oneshot_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cont && !start_s) |=> !run);
  // R5: continuous expiry keeps it running
  p_cont_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cont && !stop_s && !load) |=> run);
  // R6: status write without expiry clears the flag
  p_sts_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !expire) |=> !tmo);
  // R2: period write halts the timer
  p_load_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !run);
  // R8: stop wins over start
  p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_s |=> !run);
endmodule

// File: rtl/pit_top.sv
module pit_top #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int PER_W = 2 * HALF_W;

  logic [PER_W-1:0] period, load_val;
  logic load, run, expire;

  pit_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .expire(expire), .bus_rdata(bus_rdata),
    .period(period), .load(load), .load_val(load_val), .run(run), .irq(irq)
  );

  pit_count #(.PER_W(PER_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_val(load_val),
    .period(period), .expire(expire)
  );

  // R7: irq implies timeout pending
  p_irq_needs_to_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bus_rdata[0] || (bus_addr != 2'd0));
endmodule

// File: tb/tb_pit_top.sv
module tb_pit_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;
  int total = 0;
  int bad = 0;
  logic [15:0] d;
  int n;

  always #5 clk = ~clk;

  pit_top dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic int one_delay(int p);
    return p + 1;
  endfunction
  function automatic int after_clear(int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_to(input int limit, output int cnt);
    logic [15:0] s;
    cnt = 0;
    while (cnt <= limit) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      rd(2'd0, s);
      if (s[0]) return;
    end
  endtask

  task automatic set_period(input int p);
    wr(2'd3, 16'(p >> 16));
    wr(2'd2, 16'(p));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk(d == 16'h0, "R1 status", d, 0);
    rd(2'd1, d); chk(d == 16'h0, "R1 control", d, 0);
    rd(2'd2, d); chk(d == 16'hFFFF, "R1 period low", d, 16'hFFFF);
    rd(2'd3, d); chk(d == 16'hFFFF, "R1 period high", d, 16'hFFFF);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R2 period readback and halt on period write
    set_period(32'h0001_0203);
    rd(2'd3, d); chk(d == 16'h0001, "R2 high", d, 1);
    rd(2'd2, d); chk(d == 16'h0203, "R2 low", d, 16'h0203);
    set_period(10);
    wr(2'd1, 16'h0004);
    rd(2'd0, d); chk(d[1] == 1'b1, "R2 running before", d[1], 1);
    wr(2'd2, 16'd10);
    rd(2'd0, d); chk(d[1] == 1'b0, "R2 period write halts", d[1], 0);

    // R8 strobes read zero, stop wins
    wr(2'd1, 16'h000F);
    rd(2'd1, d); chk(d == 16'h0003, "R8 control readback", d, 3);
    rd(2'd0, d); chk(d[1] == 1'b0, "R8 stop wins", d[1], 0);

    // R3 R4 R7 random one-shot runs
    for (int i = 0; i < 8; i++) begin
      int p;
      p = int'($urandom_range(0, 20));
      set_period(p);
      wr(2'd0, 16'h0);
      wr(2'd1, 16'h0005);
      wait_to(40, n);
      chk(n == one_delay(p), "R3 oneshot delay", n, one_delay(p));
      chk(irq == 1'b1, "R7 irq with enable", irq, 1);
      rd(2'd0, d); chk(d[1] == 1'b0, "R4 running cleared", d[1], 0);
    end

    // R4 halted after one-shot, restart gives full period again
    set_period(6);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0004);
    wait_to(40, n);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    wr(2'd0, 16'h0);
    wait_to(12, n);
    chk(n == 13, "R4 no further expiry", n, 13);
    wr(2'd1, 16'h0005);
    chk(irq == 1'b0, "R7 irq low after clear", irq, 0);
    wait_to(40, n);
    chk(n == one_delay(6), "R4 restart full period", n, one_delay(6));
    wr(2'd1, 16'h0001);
    chk(irq == 1'b1, "R7 irq on late enable", irq, 1);
    wr(2'd0, 16'h0);
    chk(irq == 1'b0, "R6 clear drops irq", irq, 0);

    // R5 continuous, random periods
    for (int i = 0; i < 6; i++) begin
      int p;
      p = int'($urandom_range(1, 20));
      set_period(p);
      wr(2'd0, 16'h0);
      wr(2'd1, 16'h0006);
      wait_to(40, n);
      chk(n == one_delay(p), "R5 first interval", n, one_delay(p));
      wr(2'd0, 16'h0);
      wait_to(40, n);
      chk(n == after_clear(p), "R5 second interval", n, after_clear(p));
      rd(2'd0, d); chk(d[1] == 1'b1, "R5 still running", d[1], 1);
    end

    // R6 clear coinciding with expiry (period 0 expires every edge)
    set_period(0);
    wr(2'd1, 16'h0006);
    wait_to(5, n);
    chk(n == 1, "R3 period zero delay", n, 1);
    wr(2'd0, 16'h0);
    rd(2'd0, d); chk(d[0] == 1'b1, "R6 expiry beats clear", d[0], 1);
    wr(2'd1, 16'h000A);

    // R8 stop holds count, start resumes remainder
    set_period(10);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0004);
    repeat (4) @(negedge clk);
    wr(2'd1, 16'h0008);
    wait_to(20, n);
    chk(n == 21, "R8 no expiry while stopped", n, 21);
    wr(2'd1, 16'h0004);
    wait_to(40, n);
    chk(n == 6, "R8 resume remainder", n, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule